// File: doc/BRIEF.md
# Single-Wire Register Transaction Framer (Slave Side)

This block turns a stream of decoded bus symbols into register accesses. A symbol transceiver, outside this block, measures how long the shared wire is held low and reports one of four symbol kinds: a zero bit, a one bit, a frame start or a bus reset. After a start the framer collects the target device number, the register number and the direction bit. It then either takes in or hands out the data field, handles the single even parity bit and the closing acknowledge, and at the end issues a write strobe, a read-complete strobe or a bus-error pulse to the neighbouring register file and status logic.

During slots that the slave controls (read data, read parity, write acknowledge), the framer tells the transceiver through `slave_own_o` that the next bit slot belongs to it, and gives the level to stretch to through `slave_bit_o`. A `1` there means that the transceiver keeps the wire low long enough to signal a one. The block answers to the strap value plus one and to the broadcast number 0. Register contents and symbol timing are kept outside.

Top module: `sxn_frame_slave`

## Requirements
- R1: After a start symbol the frame is taken as a 3-bit device number, a 6-bit register number and a direction bit (1 = read, 0 = write), then data, parity and acknowledge. Every field is shifted in MSB first. An accepted write drives `reg_wr_o` high for one cycle with `reg_addr_o` set to the register number and `reg_wdata_o` set to the data.
- R2: Registers 0x00, 0x04 and 0x20 carry 8 data bits, placed in `reg_wdata_o[7:0]` with zeros above, and on reads taken from `reg_rdata_i[7:0]`. Every other register carries 16 bits.
- R3: Parity is even over every bit from the first device-number bit through the parity bit. On a write the slave owns the acknowledge slot and sends 1 when the parity is good. When it is bad the slave sends 0, pulses `bus_err_o` and gives no write strobe.
- R4: On an addressed read the slave owns each data slot and the parity slot. It presents the register data MSB first and then the parity bit that makes the frame even. It does not own the acknowledge slot.
- R5: On a read, a master acknowledge of 1 pulses `reg_rd_o` once and an acknowledge of 0 pulses `bus_err_o`.
- R6: The device number is the 2-bit strap value plus one (straps 00..11 give 1..4). The straps are sampled at each start. A frame for another number never sets `slave_own_o` and causes no strobe.
- R7: Device number 0 is broadcast. A broadcast read is ignored (no owned slot, no strobe). A broadcast write is acknowledged but only writes register 0x05, with `reg_wmask_o` = 0x0003. Unicast writes carry mask 0xFFFF.
- R8: A start symbol in the middle of a frame drops that frame without any error and begins a new one.
- R9: Bits that arrive after the acknowledge, or outside any frame, have no effect.
- R10: A bus-reset symbol abandons the frame in progress. No strobe or owned slot follows until the next start.
- R11: `reg_wr_o`, `reg_rd_o` and `bus_err_o` are single-cycle pulses, and no two of them are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 2 | Address straps; device number = strap + 1 |
| sym_vld_i | input | 1 | One-cycle flag: a symbol was decoded |
| sym_code_i | input | 2 | Symbol kind: 0 zero bit, 1 one bit, 2 start, 3 bus reset |
| slave_own_o | output | 1 | Next bit slot is driven by this slave |
| slave_bit_o | output | 1 | Level the slave sends in its owned slot |
| reg_addr_o | output | 6 | Register number of the current frame |
| reg_rdata_i | input | 16 | Register read data for `reg_addr_o` |
| reg_wr_o | output | 1 | Write strobe |
| reg_wdata_o | output | 16 | Write data |
| reg_wmask_o | output | 16 | Bit-enable mask for the write |
| reg_rd_o | output | 1 | Read completed with good acknowledge |
| bus_err_o | output | 1 | Acknowledge error pulse |

## Verification
Each strobe and error pulse comes from a register that updates on the clock edge that samples the acknowledge symbol. It is therefore due at the falling edge right after that symbol. The slot-ownership outputs depend only on state registers and are settled one cycle after the previous symbol. The driver presents each symbol for one cycle and leaves an idle cycle after it. It checks `slave_own_o` and `slave_bit_o` before sending the next slot, and queues each expected pulse just before the acknowledge. A monitor looks at every falling edge and pops the queue, so a pulse that comes early, late, doubled or unexpected shows up as a mismatch.

// File: rtl/sxn_pkg.sv
package sxn_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO  = 2'd0,
    SYM_ONE   = 2'd1,
    SYM_START = 2'd2,
    SYM_BRST  = 2'd3
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEV  = 3'd1,
    ST_REG  = 3'd2,
    ST_DIR  = 3'd3,
    ST_DATA = 3'd4,
    ST_PAR  = 3'd5,
    ST_ACK  = 3'd6,
    ST_SKIP = 3'd7
  } frame_st_e;

endpackage

// File: rtl/sxn_addr_map.sv
module sxn_addr_map #(
  parameter int DEV_W   = 3,
  parameter int REG_W   = 6,
  parameter int SHORT_A = 0,
  parameter int SHORT_B = 4,
  parameter int SHORT_C = 32,
  parameter int CTRL_A  = 5
) (
  input  logic [1:0]       strap_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [REG_W-1:0] regn_i,
  output logic             hit_o,
  output logic             bcast_o,
  output logic             short_o,
  output logic             ctrl_o
);
  logic [DEV_W-1:0] own_num;

  // straps 00..11 map onto device numbers 1..4
  assign own_num = DEV_W'(strap_i) + DEV_W'(1);
  assign hit_o   = (dev_i == own_num);
  assign bcast_o = (dev_i == '0);
  assign short_o = (regn_i == REG_W'(SHORT_A)) ||
                   (regn_i == REG_W'(SHORT_B)) ||
                   (regn_i == REG_W'(SHORT_C));
  assign ctrl_o  = (regn_i == REG_W'(CTRL_A));
endmodule

// File: rtl/sxn_parity.sv
module sxn_parity (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic acc_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) acc_o <= 1'b0;
    else if (en_i)    acc_o <= acc_o ^ bit_i;
  end
endmodule

// File: rtl/sxn_frame_slave.sv
module sxn_frame_slave
  import sxn_pkg::*;
#(
  parameter int          DEV_W      = 3,
  parameter int          REG_W      = 6,
  parameter int          LONG_W     = 16,
  parameter int          SHORT_W    = 8,
  parameter int          CTRL_REG   = 5,
  parameter logic [15:0] BCAST_MASK = 16'h0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        strap_i,
  input  logic              sym_vld_i,
  input  logic [1:0]        sym_code_i,
  output logic              slave_own_o,
  output logic              slave_bit_o,
  output logic [REG_W-1:0]  reg_addr_o,
  input  logic [LONG_W-1:0] reg_rdata_i,
  output logic              reg_wr_o,
  output logic [LONG_W-1:0] reg_wdata_o,
  output logic [LONG_W-1:0] reg_wmask_o,
  output logic              reg_rd_o,
  output logic              bus_err_o
);
  localparam int MAXF  = (LONG_W > REG_W) ? LONG_W : REG_W;
  localparam int CNT_W = $clog2(MAXF);
  localparam int ALIGN = LONG_W - SHORT_W;

  frame_st_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [DEV_W-1:0]  dev_q;
  logic [REG_W-1:0]  regn_q;
  logic [LONG_W-1:0] shreg;
  logic [1:0]        strap_q;
  logic              dir_rd_q;
  logic              ack_ok_q;

  logic is_bit, bval, is_start, is_brst;
  logic hit, bcast, short_reg, ctrl_reg;
  logic par_acc, par_en;
  logic [LONG_W-1:0] rdata_al;
  logic [CNT_W-1:0]  dlen_m1;

  assign is_bit   = sym_vld_i && (sym_code_i == SYM_ZERO || sym_code_i == SYM_ONE);
  assign bval     = sym_code_i[0];
  assign is_start = sym_vld_i && (sym_code_i == SYM_START);
  assign is_brst  = sym_vld_i && (sym_code_i == SYM_BRST);

  sxn_addr_map #(
    .DEV_W(DEV_W), .REG_W(REG_W),
    .SHORT_A(0), .SHORT_B(4), .SHORT_C(32), .CTRL_A(CTRL_REG)
  ) u_map (
    .strap_i(strap_q), .dev_i(dev_q), .regn_i(regn_q),
    .hit_o(hit), .bcast_o(bcast), .short_o(short_reg), .ctrl_o(ctrl_reg)
  );

  assign par_en = is_bit && (st == ST_DEV || st == ST_REG || st == ST_DIR || st == ST_DATA);

  sxn_parity u_par (
    .clk(clk), .rst(rst), .clr_i(is_start),
    .en_i(par_en), .bit_i(bval), .acc_o(par_acc)
  );

  // short registers are sent MSB first from bit SHORT_W-1
  assign rdata_al = short_reg ? (reg_rdata_i << ALIGN) : reg_rdata_i;
  assign dlen_m1  = short_reg ? CNT_W'(SHORT_W - 1) : CNT_W'(LONG_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      dev_q       <= '0;
      regn_q      <= '0;
      shreg       <= '0;
      strap_q     <= '0;
      dir_rd_q    <= 1'b0;
      ack_ok_q    <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      bus_err_o   <= 1'b0;
      reg_wmask_o <= '0;
    end else begin
      reg_wr_o  <= 1'b0;
      reg_rd_o  <= 1'b0;
      bus_err_o <= 1'b0;
      if (is_brst) begin
        st <= ST_IDLE;
      end else if (is_start) begin
        st      <= ST_DEV;
        cnt     <= CNT_W'(DEV_W - 1);
        strap_q <= strap_i;
      end else if (is_bit) begin
        case (st)
          ST_DEV: begin
            dev_q <= {dev_q[DEV_W-2:0], bval};
            if (cnt == '0) begin
              st  <= ST_REG;
              cnt <= CNT_W'(REG_W - 1);
            end else cnt <= cnt - 1'b1;
          end
          ST_REG: begin
            regn_q <= {regn_q[REG_W-2:0], bval};
            if (cnt == '0) st <= ST_DIR;
            else           cnt <= cnt - 1'b1;
          end
          ST_DIR: begin
            dir_rd_q <= bval;
            if (bval ? hit : (hit || bcast)) begin
              st    <= ST_DATA;
              cnt   <= dlen_m1;
              shreg <= bval ? rdata_al : '0;
            end else st <= ST_SKIP;
          end
          ST_DATA: begin
            shreg <= {shreg[LONG_W-2:0], bval};
            if (cnt == '0) st <= ST_PAR;
            else           cnt <= cnt - 1'b1;
          end
          ST_PAR: begin
            ack_ok_q <= ~(par_acc ^ bval);
            st       <= ST_ACK;
          end
          ST_ACK: begin
            st <= ST_IDLE;
            if (dir_rd_q) begin
              if (bval) reg_rd_o  <= 1'b1;
              else      bus_err_o <= 1'b1;
            end else if (!ack_ok_q) begin
              bus_err_o <= 1'b1;
            end else if (!bcast || ctrl_reg) begin
              reg_wr_o    <= 1'b1;
              reg_wmask_o <= bcast ? BCAST_MASK : '1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr_o  = regn_q;
  assign reg_wdata_o = shreg;

  always_comb begin
    slave_own_o = 1'b0;
    slave_bit_o = 1'b0;
    case (st)
      ST_DATA: begin slave_own_o = dir_rd_q;  slave_bit_o = dir_rd_q & shreg[LONG_W-1]; end
      ST_PAR:  begin slave_own_o = dir_rd_q;  slave_bit_o = dir_rd_q & par_acc;         end
      ST_ACK:  begin slave_own_o = !dir_rd_q; slave_bit_o = !dir_rd_q & ack_ok_q;       end
      default: ;
    endcase
  end

  // R11: the three result pulses are exclusive
  a_r11_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr_o, reg_rd_o, bus_err_o}));
  // R11: a write strobe lasts one cycle
  a_r11_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o);
  // R1: a write strobe always follows a sampled symbol
  a_r1_wr_after_sym: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> $past(sym_vld_i));
  // R7: only the full or the broadcast mask can accompany a write
  a_r7_mask: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> (reg_wmask_o == '1 || reg_wmask_o == BCAST_MASK));
  // R10: a bus reset leaves no owned slot and no strobe
  a_r10_brst_quiet: assert property (@(posedge clk) disable iff (rst)
    (sym_vld_i && sym_code_i == SYM_BRST) |=> (!slave_own_o && !reg_wr_o && !bus_err_o));
  // R8: a start never produces an error
  a_r8_start_noerr: assert property (@(posedge clk) disable iff (rst)
    (sym_vld_i && sym_code_i == SYM_START) |=> (!bus_err_o && !slave_own_o));
endmodule

// File: tb/test_sxn_frame_slave.sv
module test_sxn_frame_slave;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  strap;
  logic        sym_vld;
  logic [1:0]  sym_code;
  logic        slave_own, slave_bit;
  logic [5:0]  reg_addr;
  logic [15:0] reg_rdata;
  logic        reg_wr, reg_rd, bus_err;
  logic [15:0] reg_wdata, reg_wmask;

  always #4 clk = ~clk;

  sxn_frame_slave i_sxn_frame_slave (
    .clk(clk), .rst(rst), .strap_i(strap), .sym_vld_i(sym_vld), .sym_code_i(sym_code),
    .slave_own_o(slave_own), .slave_bit_o(slave_bit), .reg_addr_o(reg_addr),
    .reg_rdata_i(reg_rdata), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .reg_wmask_o(reg_wmask), .reg_rd_o(reg_rd), .bus_err_o(bus_err)
  );

  function automatic logic [15:0] rf(input logic [5:0] a);
    return {a, 4'hC, ~a};
  endfunction
  assign reg_rdata = rf(reg_addr);

  typedef struct packed {
    logic [1:0]  k;   // 1 write, 2 read done, 3 error
    logic [5:0]  a;
    logic [15:0] d;
    logic [15:0] m;
  } ev_t;

  ev_t q[$];
  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (reg_wr || reg_rd || bus_err)) begin
      ev_t e;
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected pulse act=%0h exp=none", {reg_wr, reg_rd, bus_err});
      end else begin
        e = q.pop_front();
        if ((reg_wr && e.k != 2'd1) || (reg_rd && e.k != 2'd2) || (bus_err && e.k != 2'd3)
            || reg_addr != e.a
            || (reg_wr && (reg_wdata != e.d || reg_wmask != e.m))) begin
          bad++;
          $display("FAIL R11 event act=%0h/%0h/%0h/%0h exp=%0h/%0h/%0h/%0h",
                   {reg_wr, reg_rd, bus_err}, reg_addr, reg_wdata, reg_wmask,
                   e.k, e.a, e.d, e.m);
        end
      end
    end
  end

  task automatic sym(input logic [1:0] c);
    @(negedge clk); sym_vld = 1'b1; sym_code = c;
    @(negedge clk); sym_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic sbit(input logic v);
    sym({1'b0, v});
  endtask

  function automatic bit is_short(input logic [5:0] r);
    return (r == 6'h00 || r == 6'h04 || r == 6'h20);
  endfunction

  task automatic hdr(input logic [2:0] d, input logic [5:0] r, input logic rw, inout logic p);
    p = 1'b0;
    sym(2'd2);
    for (int i = 2; i >= 0; i--) begin sbit(d[i]); p ^= d[i]; end
    for (int i = 5; i >= 0; i--) begin sbit(r[i]); p ^= r[i]; end
    sbit(rw); p ^= rw;
  endtask

  // mode 0: not addressed; 1: addressed, strobe expected; 2: acked without write
  task automatic do_write(input logic [2:0] d, input logic [5:0] r, input logic [15:0] data,
                          input bit badp, input int mode);
    logic p;
    int   n;
    ev_t  e;
    n = is_short(r) ? 8 : 16;
    hdr(d, r, 1'b0, p);
    for (int i = n - 1; i >= 0; i--) begin sbit(data[i]); p ^= data[i]; end
    sbit(badp ? ~p : p);
    if (mode == 0) begin
      chk("R6 no owned ack slot", slave_own, 1'b0);
      sbit(1'b1);
    end else begin
      chk("R3 ack slot owned", slave_own, 1'b1);
      chk("R3 ack value", slave_bit, !badp);
      if (badp) begin
        e = '{k: 2'd3, a: r, d: 16'h0, m: 16'h0};
        q.push_back(e);
      end else if (mode == 1) begin
        e = '{k: 2'd1, a: r, d: (n == 8) ? {8'h00, data[7:0]} : data,
              m: (d == 3'd0) ? 16'h0003 : 16'hFFFF};
        q.push_back(e);
      end
      sbit(!badp);
    end
  endtask

  task automatic do_read(input logic [2:0] d, input logic [5:0] r, input bit addressed,
                         input logic mack);
    logic        p;
    logic [15:0] w;
    logic        ev;
    ev_t         e;
    int          n;
    n = is_short(r) ? 8 : 16;
    w = is_short(r) ? {rf(r)[7:0], 8'h00} : rf(r);
    hdr(d, r, 1'b1, p);
    for (int i = 0; i < n; i++) begin
      ev = addressed ? w[15 - i] : 1'b0;
      if (addressed) begin
        chk("R4 data slot owned", slave_own, 1'b1);
        chk($sformatf("R2 R4 data bit %0d", i), slave_bit, ev);
      end else begin
        chk("R7 R6 read slot not owned", slave_own, 1'b0);
      end
      sbit(ev);
      p ^= ev;
    end
    if (addressed) begin
      chk("R4 parity slot owned", slave_own, 1'b1);
      chk("R4 parity value", slave_bit, p);
    end
    sbit(addressed ? p : 1'b0);
    chk("R4 ack slot belongs to master", slave_own, 1'b0);
    if (addressed) begin
      e = '{k: mack ? 2'd2 : 2'd3, a: r, d: 16'h0, m: 16'h0};
      q.push_back(e);
    end
    sbit(mack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic p;
    rst = 1'b1; strap = 2'b10; sym_vld = 1'b0; sym_code = 2'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset own", slave_own, 1'b0);
    chk("R11 reset pulses", {reg_wr, reg_rd, bus_err}, 3'b000);

    // R1: 16-bit write to own number 3
    do_write(3'd3, 6'h0A, 16'hBEEF, 0, 1);
    // R2: 8-bit write
    do_write(3'd3, 6'h20, 16'h005A, 0, 1);
    // R4 R5 R2: reads, long and short
    do_read(3'd3, 6'h09, 1, 1'b1);
    do_read(3'd3, 6'h04, 1, 1'b1);
    do_read(3'd3, 6'h00, 1, 1'b1);
    // R3: bad parity
    do_write(3'd3, 6'h0A, 16'h1234, 1, 1);
    // R5: master nack
    do_read(3'd3, 6'h21, 1, 1'b0);
    // R6: other device numbers
    do_write(3'd2, 6'h0A, 16'hAAAA, 0, 0);
    do_read(3'd4, 6'h09, 0, 1'b1);
    strap = 2'b00;
    do_write(3'd1, 6'h05, 16'h0F0F, 0, 1);
    do_write(3'd3, 6'h05, 16'h0F0F, 0, 0);
    strap = 2'b10;
    // R7: broadcast
    do_read(3'd0, 6'h09, 0, 1'b1);
    do_write(3'd0, 6'h05, 16'h1237, 0, 1);
    do_write(3'd0, 6'h0A, 16'h5555, 0, 2);
    // R8: start in the middle of a frame
    sym(2'd2); sbit(1'b0); sbit(1'b1); sbit(1'b1); sbit(1'b0);
    do_write(3'd3, 6'h11, 16'hC3C3, 0, 1);
    // R9: extra bits after the acknowledge
    for (int i = 0; i < 5; i++) begin
      sbit(i[0]);
      chk("R9 extra bit not owned", slave_own, 1'b0);
    end
    // R10: bus reset in the data field
    hdr(3'd3, 6'h0A, 1'b0, p);
    for (int i = 0; i < 5; i++) sbit(1'b1);
    sym(2'd3);
    chk("R10 abandon own", slave_own, 1'b0);
    for (int i = 0; i < 14; i++) begin
      sbit(1'b0);
      chk("R10 no owned slot after reset", slave_own, 1'b0);
    end
    do_write(3'd3, 6'h0A, 16'h0001, 0, 1);

    repeat (4) @(negedge clk);
    chk("R1 all expected pulses seen", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule